// File: doc/BRIEF.md
# DMA and Shared-RAM Write Protection Checker

This block sits in front of a set of memory regions. It judges every access request in the cycle it arrives and either grants it or blocks it before it reaches memory. Requests come from DMA engines, from a CPU, and from a coprocessor. The coprocessor issues two kinds of access: data accesses and program fetches. Each request carries the index of the subsystem that issued it.

The address space is split into equal regions, selected by the top address bits. The lowest regions are exempt and are never checked. The next regions are local RAM shared between the CPU and the coprocessor, and each one has a configurable usage mode. All remaining regions are dedicated or global regions. Every region has a configurable owning subsystem and a DMA write-lock bit.

A blocked access is classed in one of two ways:
- **Foreign:** the requester is not the rightful user of the region.
- **Owner-locked:** the owning DMA wrote to a region whose lock bit is set.

Each subsystem has one sticky flag per class, and each flag has a register that holds the first faulting address. A debug-qualified request skips every check.

Top module: `wr_guard`

## Requirements
- R1: A non-debug DMA write to a non-exempt region whose owner field differs from the requesting subsystem is blocked (`reqGrant`=0 in the same cycle). On the next clock edge it sets foreign flag bit `2*ss+0`.
- R2: A non-debug DMA write by the owning subsystem to a non-exempt region whose lock bit is 1 is blocked. On the next edge it sets owner-locked flag bit `2*ss+1`.
- R3: DMA reads are always granted. A DMA write by the owner to an unlocked region is granted.
- R4: A request with `reqDebug`=1 is always granted and never records a violation.
- R5: Requests to regions 0 and 1 (the exempt regions) are always granted and never record a violation.
- R6: A CPU access (read or write) to a local shared region is blocked as foreign only when that region's mode is 2 (coprocessor program). CPU accesses to any other region are granted.
- R7: In a local shared region, a coprocessor data access is granted only in mode 1 (coprocessor data), and a coprocessor fetch is granted only in mode 2. Any other case is blocked as foreign. Modes 0 and 3 both mean CPU-dedicated.
- R8: Flags are sticky. While a flag stays set, its address register keeps the address of the first fault.
- R9: A config write with `cfgSel`=3 clears every flag whose `cfgData` bit is 1. A violation in the same cycle as the clear wins: the flag stays set and the new address is captured.
- R10: Reset clears all flags and addresses, all lock bits, and all owner fields (owner = subsystem 0), and sets every local mode to 0.
- R11: With `reqValid`=0 there is no grant and nothing is recorded. Config writes take effect from the next cycle:
  - `cfgSel`=0 loads the lock bits, with bit r for region r.
  - `cfgSel`=1 loads the owner fields, with bit r for region r.
  - `cfgSel`=2 loads the local modes, with bits 2i+1:2i for local region i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Request address; the top REGION_W bits select the region |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqSrc | input | 2 | Requester: 0 CPU, 1 coprocessor data, 2 coprocessor fetch, 3 DMA |
| reqSs | input | SS_W | Index of the requesting subsystem |
| reqDebug | input | 1 | Debug-qualified access |
| cfgWe | input | 1 | Config write strobe |
| cfgSel | input | 2 | Config target: 0 lock bits, 1 owners, 2 local modes, 3 flag clear |
| cfgData | input | CFG_W | Config write data |
| reqGrant | output | 1 | Request may proceed to memory |
| violFlags | output | NUM_FLAGS | Sticky flags; bit 2*ss+class, where class 0 is foreign and class 1 is owner-locked |
| violAddr | output | NUM_FLAGS*ADDR_W | Captured address for flag k, in bits k*ADDR_W +: ADDR_W |

## Verification
`reqGrant` is combinational, so the bench drives each request and reads the grant in that same cycle, before the clock edge. Flags and captured addresses change at the edge, so the bench compares them one edge after the request, against a reference model updated at the same point. A config write changes grant decisions only for requests in later cycles. The model therefore applies new config after the edge and judges the request against the old config, which also checks the case where a violation and a clear land on the same edge.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;

  typedef enum logic [1:0] {
    SRC_CPU      = 2'd0,
    SRC_CP_DATA  = 2'd1,
    SRC_CP_FETCH = 2'd2,
    SRC_DMA      = 2'd3
  } srcKind_e;

  typedef enum logic [1:0] {
    MODE_CPU_OWN = 2'd0,
    MODE_CP_DATA = 2'd1,
    MODE_CP_PROG = 2'd2,
    MODE_SPARE   = 2'd3
  } localMode_e;

  typedef enum logic [1:0] {
    SEL_PROT  = 2'd0,
    SEL_OWNER = 2'd1,
    SEL_MODE  = 2'd2,
    SEL_CLEAR = 2'd3
  } cfgSel_e;

  localparam logic CLS_FOREIGN = 1'b0;
  localparam logic CLS_LOCKED  = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic logEn;
    logic logCls;
    logic protWe;
    logic ownerWe;
    logic modeWe;
    logic clrWe;
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wr_guard_ctrl.sv
module wr_guard_ctrl
  import wr_guard_pkg::*;
#(
  parameter int REGION_W   = 3,
  parameter int NUM_EXEMPT = 2,
  parameter int NUM_LOCAL  = 2,
  parameter int SS_W       = 1,
  localparam int NUM_REGIONS = 1 << REGION_W
) (
  input  logic                        reqValid,
  input  logic [REGION_W-1:0]         reqRegion,
  input  logic                        reqWrite,
  input  logic [1:0]                  reqSrc,
  input  logic [SS_W-1:0]             reqSs,
  input  logic                        reqDebug,
  input  logic                        cfgWe,
  input  logic [1:0]                  cfgSel,
  input  logic [NUM_REGIONS-1:0]      cfgProt,
  input  logic [NUM_REGIONS*SS_W-1:0] cfgOwner,
  input  logic [NUM_LOCAL*2-1:0]      cfgMode,
  output logic                        reqGrant,
  output strobe_t                     strobes
);

  logic       isExempt;
  logic       isLocal;
  logic [1:0] curMode;
  logic [SS_W-1:0] curOwner;
  logic       curProt;
  logic       block;
  logic       cls;

  // region classification
  always_comb begin
    isExempt = {1'b0, reqRegion} < (REGION_W+1)'(NUM_EXEMPT);
    isLocal  = !isExempt &&
               ({1'b0, reqRegion} < (REGION_W+1)'(NUM_EXEMPT + NUM_LOCAL));
    curMode  = MODE_CPU_OWN;
    for (int i = 0; i < NUM_LOCAL; i++) begin
      if (reqRegion == REGION_W'(NUM_EXEMPT + i)) curMode = cfgMode[2*i +: 2];
    end
    curOwner = cfgOwner[reqRegion*SS_W +: SS_W];
    curProt  = cfgProt[reqRegion];
  end

  // access decision
  always_comb begin
    block = 1'b0;
    cls   = CLS_FOREIGN;
    if (!reqDebug && !isExempt) begin
      unique case (srcKind_e'(reqSrc))
        SRC_DMA: begin
          if (reqWrite) begin
            if (curOwner != reqSs) begin
              block = 1'b1;
            end else if (curProt) begin
              block = 1'b1;
              cls   = CLS_LOCKED;
            end
          end
        end
        SRC_CPU:      block = isLocal && (curMode == MODE_CP_PROG);
        SRC_CP_DATA:  block = isLocal && (curMode != MODE_CP_DATA);
        SRC_CP_FETCH: block = isLocal && (curMode != MODE_CP_PROG);
        default:      block = 1'b0;
      endcase
    end
  end

  always_comb begin
    reqGrant        = reqValid && !block;
    strobes.logEn   = reqValid && block;
    strobes.logCls  = cls;
    strobes.protWe  = cfgWe && (cfgSel == SEL_PROT);
    strobes.ownerWe = cfgWe && (cfgSel == SEL_OWNER);
    strobes.modeWe  = cfgWe && (cfgSel == SEL_MODE);
    strobes.clrWe   = cfgWe && (cfgSel == SEL_CLEAR);
  end

endmodule

// File: rtl/wr_guard_datapath.sv
module wr_guard_datapath
  import wr_guard_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int REGION_W  = 3,
  parameter int NUM_LOCAL = 2,
  parameter int SS_W      = 1,
  parameter int CFG_W     = 8,
  localparam int NUM_REGIONS = 1 << REGION_W,
  localparam int FIDX_W      = SS_W + 1,
  localparam int NUM_FLAGS   = 1 << FIDX_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobes,
  input  logic [SS_W-1:0]             reqSs,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [CFG_W-1:0]            cfgData,
  output logic [NUM_REGIONS-1:0]      cfgProt,
  output logic [NUM_REGIONS*SS_W-1:0] cfgOwner,
  output logic [NUM_LOCAL*2-1:0]      cfgMode,
  output logic [NUM_FLAGS-1:0]        violFlags,
  output logic [NUM_FLAGS*ADDR_W-1:0] violAddr
);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgProt  <= '0;
      cfgOwner <= '0;
      cfgMode  <= '0;
    end else begin
      if (strobes.protWe)  cfgProt  <= cfgData[NUM_REGIONS-1:0];
      if (strobes.ownerWe) cfgOwner <= cfgData[NUM_REGIONS*SS_W-1:0];
      if (strobes.modeWe)  cfgMode  <= cfgData[NUM_LOCAL*2-1:0];
    end
  end

  logic [FIDX_W-1:0] hitIdx;
  assign hitIdx = {reqSs, strobes.logCls};

  // one sticky flag and capture register per subsystem and class
  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    logic hit;
    logic clr;
    logic flagQ;
    logic [ADDR_W-1:0] addrQ;

    assign hit = strobes.logEn && (hitIdx == FIDX_W'(k));
    assign clr = strobes.clrWe && cfgData[k];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ <= 1'b0;
        addrQ <= '0;
      end else begin
        flagQ <= hit | (flagQ & ~clr);
        if (hit && (!flagQ || clr)) addrQ <= reqAddr;
      end
    end

    assign violFlags[k]                 = flagQ;
    assign violAddr[k*ADDR_W +: ADDR_W] = addrQ;
  end

endmodule

// File: rtl/wr_guard.sv
module wr_guard
  import wr_guard_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int REGION_W   = 3,
  parameter int NUM_EXEMPT = 2,
  parameter int NUM_LOCAL  = 2,
  parameter int NUM_SS     = 2,
  localparam int SS_W        = (NUM_SS > 1) ? $clog2(NUM_SS) : 1,
  localparam int NUM_REGIONS = 1 << REGION_W,
  localparam int NUM_FLAGS   = 2 << SS_W,
  localparam int CFG_W       = maxOf(maxOf(NUM_REGIONS * SS_W, NUM_LOCAL * 2),
                                     maxOf(NUM_FLAGS, NUM_REGIONS))
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqWrite,
  input  logic [1:0]                  reqSrc,
  input  logic [SS_W-1:0]             reqSs,
  input  logic                        reqDebug,
  input  logic                        cfgWe,
  input  logic [1:0]                  cfgSel,
  input  logic [CFG_W-1:0]            cfgData,
  output logic                        reqGrant,
  output logic [NUM_FLAGS-1:0]        violFlags,
  output logic [NUM_FLAGS*ADDR_W-1:0] violAddr
);

  strobe_t                     strobes;
  logic [NUM_REGIONS-1:0]      cfgProt;
  logic [NUM_REGIONS*SS_W-1:0] cfgOwner;
  logic [NUM_LOCAL*2-1:0]      cfgMode;

  wr_guard_ctrl #(
    .REGION_W  (REGION_W),
    .NUM_EXEMPT(NUM_EXEMPT),
    .NUM_LOCAL (NUM_LOCAL),
    .SS_W      (SS_W)
  ) u_ctrl (
    .reqValid (reqValid),
    .reqRegion(reqAddr[ADDR_W-1 -: REGION_W]),
    .reqWrite (reqWrite),
    .reqSrc   (reqSrc),
    .reqSs    (reqSs),
    .reqDebug (reqDebug),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgProt  (cfgProt),
    .cfgOwner (cfgOwner),
    .cfgMode  (cfgMode),
    .reqGrant (reqGrant),
    .strobes  (strobes)
  );

  wr_guard_datapath #(
    .ADDR_W   (ADDR_W),
    .REGION_W (REGION_W),
    .NUM_LOCAL(NUM_LOCAL),
    .SS_W     (SS_W),
    .CFG_W    (CFG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqSs    (reqSs),
    .reqAddr  (reqAddr),
    .cfgData  (cfgData),
    .cfgProt  (cfgProt),
    .cfgOwner (cfgOwner),
    .cfgMode  (cfgMode),
    .violFlags(violFlags),
    .violAddr (violAddr)
  );

endmodule

// File: rtl/wr_guard_chk.sv
module wr_guard_chk #(
  parameter int ADDR_W     = 16,
  parameter int REGION_W   = 3,
  parameter int NUM_EXEMPT = 2,
  parameter int SS_W       = 1,
  parameter int NUM_FLAGS  = 4,
  parameter int CFG_W      = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic [ADDR_W-1:0]           reqAddr,
  input logic                        reqWrite,
  input logic [1:0]                  reqSrc,
  input logic                        reqDebug,
  input logic                        cfgWe,
  input logic [1:0]                  cfgSel,
  input logic [CFG_W-1:0]            cfgData,
  input logic                        reqGrant,
  input logic [NUM_FLAGS-1:0]        violFlags,
  input logic [NUM_FLAGS*ADDR_W-1:0] violAddr
);

  logic [NUM_FLAGS-1:0] clrVec;
  logic [NUM_FLAGS-1:0] keepMask;
  logic                 inExempt;

  assign clrVec   = (cfgWe && cfgSel == 2'd3) ? cfgData[NUM_FLAGS-1:0] : '0;
  assign keepMask = violFlags & ~clrVec;
  assign inExempt = {1'b0, reqAddr[ADDR_W-1 -: REGION_W]} < (REGION_W+1)'(NUM_EXEMPT);

  // R4
  debug_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDebug) |-> reqGrant);

  // R5
  exempt_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && inExempt) |-> reqGrant);

  // R11
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !reqGrant);

  // R3
  dma_read_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSrc == 2'd3 && !reqWrite) |-> reqGrant);

  // R1
  block_records_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqGrant) |=> (violFlags != '0));

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((violFlags & $past(keepMask)) == $past(keepMask)));

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_hold
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      keepMask[k] |=> $stable(violAddr[k*ADDR_W +: ADDR_W]));
  end

endmodule

bind wr_guard wr_guard_chk #(
  .ADDR_W    (ADDR_W),
  .REGION_W  (REGION_W),
  .NUM_EXEMPT(NUM_EXEMPT),
  .SS_W      (SS_W),
  .NUM_FLAGS (NUM_FLAGS),
  .CFG_W     (CFG_W)
) u_wr_guard_chk (.*);

// File: tb/wr_guard_bench.sv
module wr_guard_bench;

  localparam int ADDR_W = 16;
  localparam int NF     = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSrc = '0;
  logic [0:0]  reqSs = '0;
  logic        reqDebug = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [7:0]  cfgData = '0;
  logic        reqGrant;
  logic [3:0]  violFlags;
  logic [63:0] violAddr;

  int testsRun = 0;
  int testsFailed = 0;

  // reference model state
  logic [7:0]  mProt, mOwner;
  logic [3:0]  mMode;
  logic [3:0]  mFlag;
  logic [15:0] mAddr [4];

  always #10 clk = ~clk;

  wr_guard u_wr_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSrc(reqSrc), .reqSs(reqSs), .reqDebug(reqDebug),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqGrant(reqGrant), .violFlags(violFlags), .violAddr(violAddr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns {block, class}
  function automatic logic [1:0] refDecide(input logic [15:0] a, input logic w,
                                           input logic [1:0] s, input logic ss,
                                           input logic dbg);
    int r = a[15:13];
    logic [1:0] md;
    logic loc;
    if (dbg || r < 2) return 2'b00;
    loc = (r == 2 || r == 3);
    md  = loc ? mMode[2*(r-2) +: 2] : 2'd0;
    case (s)
      2'd3: begin
        if (!w) return 2'b00;
        if (mOwner[r] != ss) return 2'b10;
        if (mProt[r]) return 2'b11;
        return 2'b00;
      end
      2'd0: return (loc && md == 2'd2) ? 2'b10 : 2'b00;
      2'd1: return (loc && md != 2'd1) ? 2'b10 : 2'b00;
      default: return (loc && md != 2'd2) ? 2'b10 : 2'b00;
    endcase
  endfunction

  function automatic string tagFor(input logic [15:0] a, input logic [1:0] s,
                                   input logic dbg, input logic v, input logic [1:0] d);
    if (!v) return "R11";
    if (dbg) return "R4";
    if (a[15:13] < 2) return "R5";
    if (s == 2'd3) return d[1] ? (d[0] ? "R2" : "R1") : "R3";
    if (s == 2'd0) return "R6";
    return "R7";
  endfunction

  task automatic step(input logic v, input logic [15:0] a, input logic w,
                      input logic [1:0] s, input logic ss, input logic dbg,
                      input logic cwe, input logic [1:0] csel, input logic [7:0] cdat);
    logic [1:0] d;
    logic [3:0] clr;
    int k;
    @(negedge clk);
    reqValid = v; reqAddr = a; reqWrite = w; reqSrc = s; reqSs = ss; reqDebug = dbg;
    cfgWe = cwe; cfgSel = csel; cfgData = cdat;
    #1;
    d = refDecide(a, w, s, ss, dbg);
    check({tagFor(a, s, dbg, v, d), " grant"}, 64'(reqGrant), 64'(v && !d[1]));
    @(posedge clk);
    #1;
    clr = (cwe && csel == 2'd3) ? cdat[3:0] : 4'd0;
    k = {ss, d[0]};
    for (int i = 0; i < NF; i++) begin
      logic hit = v && d[1] && (k == i);
      if (hit && (!mFlag[i] || clr[i])) mAddr[i] = a;
      mFlag[i] = hit | (mFlag[i] & ~clr[i]);
    end
    if (cwe && csel == 2'd0) mProt = cdat;
    if (cwe && csel == 2'd1) mOwner = cdat;
    if (cwe && csel == 2'd2) mMode = cdat[3:0];
    check("R1 R2 R8 R9 flags", 64'(violFlags), 64'(mFlag));
    check("R8 R9 addr", violAddr, {mAddr[3], mAddr[2], mAddr[1], mAddr[0]});
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] dat);
    step(1'b0, 16'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, sel, dat);
  endtask

  task automatic req(input logic [15:0] a, input logic w, input logic [1:0] s,
                     input logic ss, input logic dbg);
    step(1'b1, a, w, s, ss, dbg, 1'b0, 2'd0, 8'd0);
  endtask

  initial begin
    #4_000_000;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mProt = '0; mOwner = '0; mMode = '0; mFlag = '0;
    for (int i = 0; i < 4; i++) mAddr[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset state
    check("R10 flags after reset", 64'(violFlags), 64'd0);
    check("R10 addr after reset", violAddr, 64'd0);
    req(16'hC010, 1'b1, 2'd3, 1'b0, 1'b0);   // R10 owner 0 -> granted
    req(16'h4000, 1'b0, 2'd0, 1'b0, 1'b0);   // R10 mode 0 -> CPU ok
    req(16'h4004, 1'b0, 2'd1, 1'b1, 1'b0);   // R7 cp data blocked in mode 0
    // R1 foreign DMA write, then R8 keeps first address
    req(16'hC100, 1'b1, 2'd3, 1'b1, 1'b0);
    req(16'hE200, 1'b1, 2'd3, 1'b1, 1'b0);
    // R4 debug bypass
    req(16'hE300, 1'b1, 2'd3, 1'b1, 1'b1);
    // R5 exempt
    req(16'h0010, 1'b1, 2'd3, 1'b1, 1'b0);
    req(16'h2010, 1'b1, 2'd3, 1'b1, 1'b0);
    // R2 owner lock
    cfg(2'd0, 8'hF0);
    req(16'hA000, 1'b1, 2'd3, 1'b0, 1'b0);
    req(16'hA000, 1'b0, 2'd3, 1'b0, 1'b0);   // R3 read granted
    // R6 R7 modes: region2 prog, region3 data
    cfg(2'd2, 8'b0001_10);
    req(16'h4000, 1'b0, 2'd0, 1'b0, 1'b0);   // R6 CPU read blocked
    req(16'h6000, 1'b1, 2'd0, 1'b0, 1'b0);   // R6 CPU ok in data mode
    req(16'h4000, 1'b0, 2'd2, 1'b0, 1'b0);   // R7 fetch ok in prog
    req(16'h6000, 1'b0, 2'd1, 1'b0, 1'b0);   // R7 data ok in data mode
    req(16'h6000, 1'b0, 2'd2, 1'b0, 1'b0);   // R7 fetch blocked
    // R9 clear and clear-versus-violation priority
    cfg(2'd3, 8'h02);
    step(1'b1, 16'hC777, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 2'd3, 8'h04);
    check("R9 priority flag", 64'(violFlags[2]), 64'd1);
    check("R9 priority addr", 64'(violAddr[47:32]), 64'hC777);
    // R11 idle
    step(1'b0, 16'hC000, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic cw = ($urandom % 6) == 0;
      step(($urandom % 8) != 0, 16'($urandom), 1'($urandom), 2'($urandom),
           1'($urandom), ($urandom % 8) == 0, cw, 2'($urandom), 8'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule